// File: doc/BRIEF.md
# Arbitrated Host Bus Interface

This block is the slave-side port through which an asynchronous host processor reaches a 16-bit shared RAM and a small register file inside a chip. The same RAM is also used by an internal protocol engine. A host cycle starts when select and strobe are both low. Both pins pass through a synchronizer. The block then waits until the engine is not using the RAM, and grants the cycle by driving an active-low enable. The transfer finishes with an active-low ready a fixed number of clocks later. The enable and ready both return high once the host raises strobe.

The memory/register and read/write controls are captured on the first falling clock edge after the grant. The address and write data are captured on the first rising edge after it, and a write is committed on that same edge. A polarity input decides whether a low or a high read/write level means write. A per-cycle slip input models a synchronizer that missed its setup window. It delays the address/data capture and the ready by exactly one clock. The protocol engine reaches the RAM through a request/grant port.

Top module: `hbi_host_if`

## Requirements
- R1: After reset, enable and ready are high, read data is zero and the engine grant is low.
- R2: With the RAM free, enable goes low after the third rising edge following the moment select and strobe are both driven low. Select may then be raised without ending the cycle.
- R3: Ready falls exactly WAIT_CLKS (default 3) rising edges after enable falls, and it is only low while enable is low.
- R4: When the slip input is high at the grant edge, the address/data capture moves one edge later and ready falls WAIT_CLKS+1 edges after enable.
- R5: While the engine holds the RAM, enable stays high. The host is granted only after the engine drops its request, and enable and the engine grant are never low and high together.
- R6: An engine request raised during a granted host cycle is not granted until enable has returned high.
- R7: With polarity 1, a read/write level of 0 means write. With polarity 0, a level of 1 means write.
- R8: Memory/register select 1 addresses the RAM by address bits 11..0, and 0 addresses the 32 registers by bits 4..0. The registers reset to zero, and the two stores are separate.
- R9: On a read, the read-data output carries the addressed word while ready is low. At all other times, and on writes, it is zero.
- R10: Enable and ready return high after the third rising edge following the rise of strobe.
- R11: Changes to memory/register select, read/write, address or write data after their capture edges do not affect the cycle.
- R12: Through its grant, the engine can write the RAM and read it back one clock after presenting an address. The host sees the engine's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host select, active low |
| host_strb_n | input | 1 | Host strobe, active low |
| host_mem_sel | input | 1 | 1 = RAM, 0 = registers |
| host_rw | input | 1 | Read/write level, sense set by host_pol |
| host_pol | input | 1 | Read/write polarity select |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_slip | input | 1 | Missed-setup model: adds one clock to the cycle |
| host_en_n | output | 1 | Cycle grant, active low |
| host_rdy_n | output | 1 | Transfer complete, active low |
| host_rdata | output | 16 | Read data |
| eng_req | input | 1 | Engine RAM request |
| eng_gnt | output | 1 | Engine RAM grant |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 12 | Engine RAM address |
| eng_wdata | input | 16 | Engine write data |
| eng_rdata | output | 16 | Engine read data, valid one clock after the address |

## Verification
The assertions assume that the host keeps strobe low until it has seen ready, or else accepts an aborted transfer. They also assume that the engine drives its write enable only while it holds the grant. The stimulus changes inputs only mid-cycle, well before the falling edge. It changes control, address and data only after their capture edges. The engine accesses the RAM only during steps in which the grant has been observed, and it clears its write enable in the same step in which it drops the request.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } hbi_state_t;

  typedef struct packed {
    logic mem;
    logic wr;
  } hbi_ctrl_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int WAIT_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic rel_s,
  input  logic slip_in,
  input  logic mem_sel_in,
  input  logic rw_in,
  input  logic pol_in,
  input  logic eng_req,
  output logic en_n,
  output logic rdy_n,
  output logic fire,
  output logic load_rdata,
  output logic mem_eff,
  output logic wr_eff,
  output logic eng_own
);
  localparam int CW = $clog2(WAIT_CLKS + 3) + 1;

  hbi_state_t state;
  logic [CW-1:0] cnt;
  logic slip_q;
  logic [CW-1:0] latch_at;
  logic [CW-1:0] rdy_at;
  logic host_go;

  hbi_ctrl_t ctrl_live;
  hbi_ctrl_t ctrl_q;
  logic ctrl_vld;

  assign latch_at = slip_q ? CW'(2) : CW'(1);
  assign rdy_at   = CW'(WAIT_CLKS) + CW'(slip_q);
  assign host_go  = (state == ST_IDLE) && req_s && !eng_own && !eng_req;
  assign fire       = (state == ST_BUSY) && (cnt == latch_at) && !rel_s;
  assign load_rdata = (state == ST_BUSY) && (cnt == rdy_at) && !rel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      en_n    <= 1'b1;
      rdy_n   <= 1'b1;
      cnt     <= '0;
      slip_q  <= 1'b0;
      eng_own <= 1'b0;
    end else begin
      eng_own <= eng_req && (eng_own || ((state == ST_IDLE) && !host_go));
      case (state)
        ST_IDLE: begin
          if (host_go) begin
            state  <= ST_BUSY;
            en_n   <= 1'b0;
            cnt    <= CW'(1);
            slip_q <= slip_in;
          end
        end
        ST_BUSY: begin
          if (rel_s) begin
            state <= ST_IDLE;
            en_n  <= 1'b1;
            rdy_n <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
            if (cnt == rdy_at) begin
              rdy_n <= 1'b0;
              state <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (rel_s) begin
            state <= ST_IDLE;
            en_n  <= 1'b1;
            rdy_n <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // control capture on the first falling edge after the grant
  assign ctrl_live.mem = mem_sel_in;
  assign ctrl_live.wr  = pol_in ? !rw_in : rw_in;

  always_ff @(negedge clk) begin
    if (rst) begin
      ctrl_vld <= 1'b0;
      ctrl_q   <= '0;
    end else if (en_n) begin
      ctrl_vld <= 1'b0;
    end else if (!ctrl_vld) begin
      ctrl_vld <= 1'b1;
      ctrl_q   <= ctrl_live;
    end
  end

  assign mem_eff = ctrl_vld ? ctrl_q.mem : ctrl_live.mem;
  assign wr_eff  = ctrl_vld ? ctrl_q.wr  : ctrl_live.wr;

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(en_n) |-> ($past(req_s) && !$past(eng_own))); // R2
  AST_RDY_INSIDE_EN: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> !en_n); // R3
  AST_RDY_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> !$past(en_n)); // R3
  AST_NO_SHARED_RAM: assert property (@(posedge clk) disable iff (rst)
    !(eng_own && !en_n)); // R5
  AST_ENG_WAITS_HOST: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_own) |-> $past(en_n)); // R6
  AST_RELEASE_ON_STRB: assert property (@(posedge clk) disable iff (rst)
    $rose(en_n) |-> $past(rel_s)); // R10
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_vld && $past(ctrl_vld)) |-> $stable(ctrl_q)); // R11
endmodule

// File: rtl/hbi_store.sv
module hbi_store #(
  parameter int DATA_W = 16,
  parameter int RAM_AW = 12,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_fire,
  input  logic              host_mem,
  input  logic              host_wr,
  input  logic [RAM_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              eng_own,
  input  logic              eng_we,
  input  logic [RAM_AW-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] reg_q
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int NREG      = 1 << REG_AW;

  logic [DATA_W-1:0] mem  [RAM_DEPTH];
  logic [DATA_W-1:0] regs [NREG];

  logic              host_ram;
  logic              ram_en;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_a;
  logic [DATA_W-1:0] ram_d;
  logic [REG_AW-1:0] reg_idx;

  assign host_ram = host_fire && host_mem;
  assign ram_en   = host_ram || eng_own;
  assign ram_we   = host_ram ? host_wr : (eng_own && eng_we);
  assign ram_a    = host_ram ? host_addr : eng_addr;
  assign ram_d    = host_ram ? host_wdata : eng_wdata;
  assign reg_idx  = host_addr[REG_AW-1:0];

  // single port, read-first: block RAM inference
  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_a] <= ram_d;
      ram_q <= mem[ram_a];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      reg_q <= '0;
    end else if (host_fire && !host_mem) begin
      if (host_wr) regs[reg_idx] <= host_wdata;
      reg_q <= regs[reg_idx];
    end
  end

  AST_ONE_RAM_USER: assert property (@(posedge clk) disable iff (rst)
    !(host_ram && eng_own)); // R5
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int RAM_AW      = 12,
  parameter int REG_AW      = 5,
  parameter int WAIT_CLKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_strb_n,
  input  logic              host_mem_sel,
  input  logic              host_rw,
  input  logic              host_pol,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_slip,
  output logic              host_en_n,
  output logic              host_rdy_n,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_req,
  output logic              eng_gnt,
  input  logic              eng_we,
  input  logic [RAM_AW-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] eng_rdata
);
  logic [1:0] pins_s;
  logic req_s, rel_s;
  logic fire, load_rdata, mem_eff, wr_eff, eng_own;
  logic [DATA_W-1:0] ram_q, reg_q;
  logic unused_addr_hi;

  assign unused_addr_hi = ^host_addr[ADDR_W-1:RAM_AW];

  hbi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
    .clk(clk), .rst(rst), .d({host_sel_n, host_strb_n}), .q(pins_s)
  );

  assign req_s = !pins_s[1] && !pins_s[0];
  assign rel_s = pins_s[0];

  hbi_ctrl #(.WAIT_CLKS(WAIT_CLKS)) ctrl_i (
    .clk(clk), .rst(rst), .req_s(req_s), .rel_s(rel_s),
    .slip_in(host_slip), .mem_sel_in(host_mem_sel), .rw_in(host_rw),
    .pol_in(host_pol), .eng_req(eng_req), .en_n(host_en_n),
    .rdy_n(host_rdy_n), .fire(fire), .load_rdata(load_rdata),
    .mem_eff(mem_eff), .wr_eff(wr_eff), .eng_own(eng_own)
  );

  hbi_store #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW)) store_i (
    .clk(clk), .rst(rst), .host_fire(fire), .host_mem(mem_eff),
    .host_wr(wr_eff), .host_addr(host_addr[RAM_AW-1:0]),
    .host_wdata(host_wdata), .eng_own(eng_own), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .ram_q(ram_q), .reg_q(reg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (load_rdata) begin
      host_rdata <= wr_eff ? '0 : (mem_eff ? ram_q : reg_q);
    end else if (!host_rdy_n && rel_s) begin
      host_rdata <= '0;
    end
  end

  assign eng_gnt   = eng_own;
  assign eng_rdata = ram_q;

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    host_rdy_n |-> (host_rdata == '0)); // R9
endmodule

// File: tb/hbi_host_if_tb_top.sv
module hbi_host_if_tb_top;
  localparam int WAIT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel_n = 1'b1, host_strb_n = 1'b1, host_mem_sel = 1'b1;
  logic host_rw = 1'b1, host_pol = 1'b1, host_slip = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic host_en_n, host_rdy_n;
  logic [15:0] host_rdata;
  logic eng_req = 1'b0, eng_we = 1'b0;
  logic [11:0] eng_addr = '0;
  logic [15:0] eng_wdata = '0;
  logic eng_gnt;
  logic [15:0] eng_rdata;

  int checks = 0, fails = 0;
  int last_grant = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [15:0] ram_m [int];
  logic [15:0] reg_m [int];

  always #10 clk = ~clk;

  hbi_host_if dut_i (
    .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_strb_n(host_strb_n),
    .host_mem_sel(host_mem_sel), .host_rw(host_rw), .host_pol(host_pol),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_slip(host_slip),
    .host_en_n(host_en_n), .host_rdy_n(host_rdy_n), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_gnt(eng_gnt), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  task automatic step;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input bit mem, input logic [15:0] a);
    int key;
    if (mem) begin
      key = int'(a[11:0]);
      return ram_m.exists(key) ? ram_m[key] : 16'h0;
    end
    key = int'(a[4:0]);
    return reg_m.exists(key) ? reg_m[key] : 16'h0;
  endfunction

  // driver: one host cycle, expected read data pushed to the scoreboard
  task automatic host_cycle(input bit mem, input bit wr, input bit pol,
                            input bit slip, input bit perturb, input bit contended,
                            input logic [15:0] addr, input logic [15:0] data,
                            input string tag);
    int n, m, k;
    host_mem_sel = mem;
    host_pol     = pol;
    host_rw      = wr ? !pol : pol;
    host_addr    = addr;
    host_wdata   = data;
    host_slip    = slip;
    if (wr) begin
      if (mem) ram_m[int'(addr[11:0])] = data;
      else     reg_m[int'(addr[4:0])]  = data;
      exp_q.push_back(16'h0);
    end else begin
      exp_q.push_back(model_rd(mem, addr));
    end
    tag_q.push_back(tag);
    host_sel_n  = 1'b0;
    host_strb_n = 1'b0;
    n = 0;
    do begin step(); n++; end while (host_en_n && n < 3000);
    last_grant = n;
    if (!contended) chk(n == 3, "R2", "edges to enable", n, 3);
    host_sel_n = 1'b1; // R2: select released, cycle must go on
    m = 0;
    do begin
      step(); m++;
      if (m == 1 && perturb) begin // R11: after both capture edges
        host_addr    = addr ^ 16'h0040;
        host_rw      = !host_rw;
        host_mem_sel = !mem;
        host_wdata   = ~data;
      end
    end while (host_rdy_n && m < 50);
    host_slip = 1'b0;
    if (slip) chk(m == WAIT + 1, "R4", "edges enable->ready", m, WAIT + 1);
    else      chk(m == WAIT, "R3", "edges enable->ready", m, WAIT);
    chk(!host_en_n, "R3", "enable low with ready", host_en_n, 0);
    host_strb_n = 1'b1;
    k = 0;
    do begin step(); k++; end while (!host_en_n && k < 50);
    chk(k == 3 && host_rdy_n, "R10", "edges strobe->release", k, 3);
    chk(host_rdata == 16'h0, "R9", "rdata after release", host_rdata, 0);
  endtask

  task automatic eng_acquire;
    int n;
    eng_req = 1'b1;
    n = 0;
    do begin step(); n++; end while (!eng_gnt && n < 50);
    chk(eng_gnt, "R12", "engine grant", eng_gnt, 1);
  endtask

  task automatic eng_release;
    eng_req = 1'b0;
    eng_we  = 1'b0;
    step();
  endtask

  task automatic eng_write(input logic [11:0] a, input logic [15:0] d);
    eng_we = 1'b1; eng_addr = a; eng_wdata = d;
    ram_m[int'(a)] = d;
    step();
    eng_we = 1'b0;
  endtask

  task automatic eng_read(input logic [11:0] a, input logic [15:0] exp);
    eng_we = 1'b0; eng_addr = a;
    step();
    chk(eng_rdata == exp, "R12", "engine read", eng_rdata, exp);
  endtask

  // monitor: compares read data when ready falls, watches RAM ownership
  initial begin
    logic prev_rdy;
    prev_rdy = 1'b1;
    forever begin
      @(posedge clk);
      #6;
      if (!rst) begin
        if (eng_gnt && !host_en_n)
          chk(0, "R5", "engine grant during host enable", 1, 0);
        if (!host_rdy_n && prev_rdy) begin
          if (exp_q.size() == 0) begin
            chk(0, "R9", "unexpected ready", 1, 0);
          end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(host_rdata == e, t, "read data", host_rdata, e);
          end
        end
        prev_rdy = host_rdy_n;
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) step();
    rst = 1'b0;
    step();
    // R1
    chk(host_en_n && host_rdy_n, "R1", "enable/ready after reset",
        {host_en_n, host_rdy_n}, 3);
    chk(host_rdata == 0, "R1", "rdata after reset", host_rdata, 0);
    chk(!eng_gnt, "R1", "engine grant after reset", eng_gnt, 0);
    repeat (3) step();

    // R7 polarity 1 then 0, R3 timing
    host_cycle(1, 1, 1, 0, 0, 0, 16'h0010, 16'h1234, "R7");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0010, 16'h0, "R7");
    host_cycle(1, 1, 0, 0, 0, 0, 16'h0020, 16'hBEEF, "R7");
    host_cycle(1, 0, 0, 0, 0, 0, 16'h0020, 16'h0, "R7");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0020, 16'h0, "R7");

    // R8 separate stores and address decode
    host_cycle(0, 0, 1, 0, 0, 0, 16'h0007, 16'h0, "R8");
    host_cycle(0, 1, 1, 0, 0, 0, 16'h0003, 16'h5A5A, "R8");
    host_cycle(1, 1, 1, 0, 0, 0, 16'h0003, 16'h1111, "R8");
    host_cycle(0, 0, 1, 0, 0, 0, 16'h0003, 16'h0, "R8");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0003, 16'h0, "R8");
    host_cycle(0, 0, 1, 0, 0, 0, 16'h0023, 16'h0, "R8");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h1003, 16'h0, "R8");

    // R4 slip on write and read
    host_cycle(1, 1, 1, 1, 0, 0, 16'h0030, 16'h4321, "R4");
    host_cycle(1, 0, 1, 1, 0, 0, 16'h0030, 16'h0, "R4");
    host_cycle(0, 0, 0, 1, 0, 0, 16'h0003, 16'h0, "R4");

    // R11 late changes ignored
    host_cycle(1, 1, 1, 0, 0, 0, 16'h0004, 16'hAAAA, "R11");
    host_cycle(1, 1, 1, 0, 1, 0, 16'h0044, 16'h7777, "R11");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0044, 16'h0, "R11");
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0004, 16'h0, "R11");
    host_cycle(0, 0, 1, 0, 0, 0, 16'h0004, 16'h0, "R11");

    // R12 engine port
    eng_acquire();
    eng_write(12'h100, 16'hC0DE);
    eng_read(12'h100, 16'hC0DE);
    eng_read(12'h030, 16'h4321);
    eng_release();
    host_cycle(1, 0, 1, 0, 0, 0, 16'h0100, 16'h0, "R12");

    // R5 contended host cycle
    eng_acquire();
    fork
      begin
        repeat (30) step();
        eng_release();
      end
      host_cycle(1, 0, 1, 0, 0, 1, 16'h0100, 16'h0, "R5");
    join
    chk(last_grant > 30, "R5", "grant held off by engine", last_grant, 31);

    // R6 engine request during host cycle
    fork
      host_cycle(1, 0, 1, 0, 0, 0, 16'h0010, 16'h0, "R6");
      begin
        int n;
        while (host_en_n) step();
        eng_req = 1'b1;
        n = 0;
        do begin step(); n++; end while (!eng_gnt && n < 60);
        chk(eng_gnt && host_en_n, "R6", "engine granted after host release",
            {eng_gnt, host_en_n}, 3);
      end
    join
    eng_release();
    repeat (3) step();
    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule